// File: doc/BRIEF.md
# Double-Buffered Byte-Selectable Converter Code Register

This block is the digital front end of a parallel-input data converter, written as a synchronous model. A host writes a code into an input register through a data bus. Each half of the bus has its own active-low lane select. An active-low write strobe opens the selected halves, and its rising edge closes them. A second register holds the code that is presented to the converter. That register is opened by an active-low load strobe and closes on the load strobe's rising edge.

When every strobe and both lane selects are low, the two stages are transparent and the output tracks the bus. An active-low clear input overrides every other control. The clear input, and the synchronous reset, force both registers to midscale or to zero, depending on a strap input.

All control and data pins pass through a pipeline of `SYNC_STAGES` flops before they are used. Edges are detected on the synchronized values. The output code is registered. A one-cycle update pulse marks every cycle in which the output code takes a new value.

Top module: `dacfe_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, both registers take 0x8000 if `mid_sel` is 1, or 0x0000 if it is 0, and `upd_o` is 0.
- R2: Bits 7:0 of the input register take bits 7:0 of the bus in any cycle where `sel_lo_n` is low and `wr_n` is low. They also take them in the cycle where `wr_n` rises. In every other cycle they keep their value.
- R3: Bits 15:8 of the input register follow the same rule as R2, using `sel_hi_n` and bits 15:8 of the bus.
- R4: Writing the upper lane first and the lower lane second gives the same stored code as the opposite order.
- R5: While `ld_n` is low, and in the cycle where it rises, the converter register takes the next input register value. While `ld_n` stays high, `code_o` holds.
- R6: With both lane selects, `wr_n` and `ld_n` all low, `code_o` equals the bus value seen by the synchronized stage.
- R7: With only `sel_lo_n` low and `wr_n` and `ld_n` low, `code_o` combines the live lower byte of the bus with the stored upper byte.
- R8: A write strobe while both lane selects are high leaves the input register unchanged. A later load then transfers the old code.
- R9: While the synchronized `clr_n` is low, both registers take 0x8000 if `mid_sel` is 1, or 0x0000 if it is 0, whatever the other controls are.
- R10: When the write rising edge and the load rising edge fall in the same synchronized cycle, the converter register takes the value that the write just captured.
- R11: `upd_o` is 1 in exactly those cycles where `code_o` differs from its value in the cycle before.
- R12: A change on a pin, driven between clock edges, reaches `code_o` on the third following edge when `SYNC_STAGES` is 2 (`SYNC_STAGES`+1 edges in general).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every pin is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_i | input | DATA_W | Parallel data bus |
| sel_lo_n | input | 1 | Active-low select of the lower lane |
| sel_hi_n | input | 1 | Active-low select of the upper lane |
| wr_n | input | 1 | Active-low write strobe |
| ld_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Active-low clear; overrides every other control |
| mid_sel | input | 1 | Static strap: 1 selects midscale, 0 selects zero for clear and reset |
| code_o | output | DATA_W | Registered converter code |
| upd_o | output | 1 | One-cycle pulse when code_o changes |

## Verification
The bench builds the block with its defaults: `DATA_W` of 16, which gives two 8-bit lanes, and `SYNC_STAGES` of 2. The short pipeline keeps every pin-to-output path at three edges. That makes it cheap to line up a write-strobe rise and a load-strobe rise in the same synchronized cycle, and to resolve the exact edge at which a pin change first shows on the output. A behavioural model is compared against the outputs on every clock. On top of that, directed sequences check:
- lane ordering;
- single-lane pass-through;
- deselected writes;
- clear under both strap values;
- a mid-run reset.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  // Synchronized control group, all active low.
  typedef struct packed {
    logic clr_n;
    logic ld_n;
    logic wr_n;
    logic sel_hi_n;
    logic sel_lo_n;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam int LANES = 2;

  // True in the cycle a sampled active-low strobe returns high.
  function automatic logic rising(input logic now_v, input logic prev_v);
    return now_v && !prev_v;
  endfunction

  // A lane accepts bus data while open or on the closing edge.
  function automatic logic lane_open(input logic sel_n, input logic wr_n,
                                     input logic wr_rise);
    return !sel_n && (!wr_n || wr_rise);
  endfunction

  // Second stage loads while its strobe is low or on its closing edge.
  function automatic logic stage_load(input logic ld_n, input logic ld_rise);
    return !ld_n || ld_rise;
  endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg <= '1;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/dacfe_in_stage.sv
module dacfe_in_stage
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] clr_val,
  input  logic              clr_act,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              wr_n,
  input  logic              wr_rise,
  input  logic [DATA_W-1:0] bus,
  output logic [LANES-1:0]  lane_open_o,
  output logic [DATA_W-1:0] in_next,
  output logic [DATA_W-1:0] in_q
);

  localparam int LANE_W = DATA_W / LANES;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int LO = l * LANE_W;
    assign lane_open_o[l] = lane_open(lane_sel_n[l], wr_n, wr_rise);
    assign in_next[LO +: LANE_W] = clr_act        ? clr_val[LO +: LANE_W] :
                                   lane_open_o[l] ? bus[LO +: LANE_W]     :
                                                    in_q[LO +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) in_q <= clr_val;
    else        in_q <= in_next;
  end

endmodule

// File: rtl/dacfe_out_stage.sv
module dacfe_out_stage
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] clr_val,
  input  logic              clr_act,
  input  logic              ld_n,
  input  logic              ld_rise,
  input  logic [DATA_W-1:0] in_next,
  output logic              load_o,
  output logic [DATA_W-1:0] code_q,
  output logic              upd_q
);

  logic [DATA_W-1:0] code_next;

  assign load_o = stage_load(ld_n, ld_rise);

  always_comb begin
    if (clr_act)     code_next = clr_val;
    else if (load_o) code_next = in_next;
    else             code_next = code_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= clr_val;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_next;
      upd_q  <= (code_next != code_q);
    end
  end

endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              sel_lo_n,
  input  logic              sel_hi_n,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic              clr_n,
  input  logic              mid_sel,
  output logic [DATA_W-1:0] code_o,
  output logic              upd_o
);

  localparam int PIPE_W = DATA_W + CTL_W;

  ctl_t              pin_ctl, s_ctl;
  logic [PIPE_W-1:0] pipe_in, pipe_out;
  logic [DATA_W-1:0] s_bus;
  logic              p_wr_n, p_ld_n;
  logic              wr_rise, ld_rise, clr_act, load_w;
  logic [DATA_W-1:0] clr_val, in_next, in_q;
  logic [LANES-1:0]  lane_open_w;

  assign pin_ctl.clr_n    = clr_n;
  assign pin_ctl.ld_n     = ld_n;
  assign pin_ctl.wr_n     = wr_n;
  assign pin_ctl.sel_hi_n = sel_hi_n;
  assign pin_ctl.sel_lo_n = sel_lo_n;
  assign pipe_in          = {bus_i, pin_ctl};

  // Data travels with its controls so strobe/data alignment is kept.
  dacfe_sync #(.W(PIPE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pipe_in),
    .q_o   (pipe_out)
  );

  assign {s_bus, s_ctl} = pipe_out;

  always_ff @(posedge clk) begin
    if (!rst_n) {p_wr_n, p_ld_n} <= 2'b11;
    else        {p_wr_n, p_ld_n} <= {s_ctl.wr_n, s_ctl.ld_n};
  end

  assign wr_rise = rising(s_ctl.wr_n, p_wr_n);
  assign ld_rise = rising(s_ctl.ld_n, p_ld_n);
  assign clr_act = !s_ctl.clr_n;
  assign clr_val = {mid_sel, {(DATA_W-1){1'b0}}};

  dacfe_in_stage #(.DATA_W(DATA_W)) u_in (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_val     (clr_val),
    .clr_act     (clr_act),
    .lane_sel_n  ({s_ctl.sel_hi_n, s_ctl.sel_lo_n}),
    .wr_n        (s_ctl.wr_n),
    .wr_rise     (wr_rise),
    .bus         (s_bus),
    .lane_open_o (lane_open_w),
    .in_next     (in_next),
    .in_q        (in_q)
  );

  dacfe_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_val (clr_val),
    .clr_act (clr_act),
    .ld_n    (s_ctl.ld_n),
    .ld_rise (ld_rise),
    .in_next (in_next),
    .load_o  (load_w),
    .code_q  (code_o),
    .upd_q   (upd_o)
  );

endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mid_sel,
  input logic [DATA_W-1:0] s_bus,
  input logic              s_sel_lo_n,
  input logic              s_sel_hi_n,
  input logic              s_wr_n,
  input logic              s_ld_n,
  input logic              p_ld_n,
  input logic              clr_act,
  input logic              wr_rise,
  input logic              ld_rise,
  input logic [DATA_W-1:0] in_q,
  input logic [DATA_W-1:0] code_o,
  input logic              upd_o
);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> (code_o == {$past(mid_sel), {(DATA_W-1){1'b0}}}));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ld_n && p_ld_n && !clr_act) |=> $stable(code_o));

  p_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_sel_lo_n && s_sel_hi_n && !clr_act) |=> $stable(in_q));

  p_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && !s_sel_lo_n && !s_sel_hi_n && !s_wr_n && !s_ld_n)
      |=> (code_o == $past(s_bus)));

  p_dual_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && wr_rise && ld_rise && !s_sel_lo_n && !s_sel_hi_n)
      |=> (code_o == $past(s_bus)));

  p_update_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o == (code_o != $past(code_o)));

endmodule

bind dacfe_top dacfe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mid_sel    (mid_sel),
  .s_bus      (s_bus),
  .s_sel_lo_n (s_ctl.sel_lo_n),
  .s_sel_hi_n (s_ctl.sel_hi_n),
  .s_wr_n     (s_ctl.wr_n),
  .s_ld_n     (s_ctl.ld_n),
  .p_ld_n     (p_ld_n),
  .clr_act    (clr_act),
  .wr_rise    (wr_rise),
  .ld_rise    (ld_rise),
  .in_q       (in_q),
  .code_o     (code_o),
  .upd_o      (upd_o)
);

// File: tb/tb_dacfe_top.sv
module tb_dacfe_top;

  localparam int CLK_P = 10;
  localparam int SY    = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus = 16'h0000;
  logic        sl = 1'b1, sh = 1'b1, wr = 1'b1, ld = 1'b1, clr = 1'b1;
  logic        mid = 1'b1;
  logic [15:0] code;
  logic        upd;

  int tests = 0, fails = 0, upd_cnt = 0;
  bit started = 0, done = 0;

  // Reference model state (behavioural, integer based).
  logic [20:0] hist [0:SY];
  logic [20:0] s_rec, p_rec;
  int m_in, m_code, m_old, clrv;
  bit m_upd;

  always #(CLK_P/2) clk = ~clk;

  dacfe_top #(.DATA_W(16), .SYNC_STAGES(SY)) dut (
    .clk(clk), .rst_n(rst_n), .bus_i(bus), .sel_lo_n(sl), .sel_hi_n(sh),
    .wr_n(wr), .ld_n(ld), .clr_n(clr), .mid_sel(mid), .code_o(code), .upd_o(upd)
  );

  // Record layout: [20:5] bus, [4] clear, [3] load, [2] write, [1] upper, [0] lower.
  always @(posedge clk) begin
    started = 1;
    clrv = mid ? 32768 : 0;
    if (!rst_n) begin
      for (int i = 0; i <= SY; i++) hist[i] = '1;
      m_in = clrv; m_code = clrv; m_upd = 0;
    end else begin
      s_rec = hist[SY-1];
      p_rec = hist[SY];
      m_old = m_code;
      if (!s_rec[4]) begin
        m_in = clrv; m_code = clrv;
      end else begin
        if (!s_rec[0] && (!s_rec[2] || !p_rec[2]))
          m_in = (m_in & 32'hFF00) | (int'(s_rec[20:5]) & 32'h00FF);
        if (!s_rec[1] && (!s_rec[2] || !p_rec[2]))
          m_in = (m_in & 32'h00FF) | (int'(s_rec[20:5]) & 32'hFF00);
        if (!s_rec[3] || !p_rec[3]) m_code = m_in;
      end
      m_upd = (m_code != m_old);
      for (int i = SY; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = {bus, clr, ld, wr, sh, sl};
    end
  end

  // Per-cycle comparison against the model (R12 timing, R11 pulse).
  always @(negedge clk) begin
    if (started && !done) begin
      tests++;
      if (code !== m_code[15:0] || upd !== m_upd) begin
        fails++;
        $display("FAIL R12 model t=%0t code=%h upd=%b expected code=%h upd=%b",
                 $time, code, upd, m_code[15:0], m_upd);
      end
      if (upd === 1'b1) upd_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] b, input logic l, input logic h,
                     input logic w, input logic d, input logic c);
    @(negedge clk);
    bus = b; sl = l; sh = h; wr = w; ld = d; clr = c;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ld_pulse();
    put(bus, 1, 1, 1, 0, 1);
    put(bus, 1, 1, 1, 1, 1);
    waitn(5);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset with midscale strap
    waitn(4);
    chk("R1 reset midscale", code, 16'h8000);
    chk("R1 upd in reset", {15'b0, upd}, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    waitn(4);

    // R2: lower lane write; R5: output holds while load high
    put(16'h12AB, 0, 1, 0, 1, 1); waitn(2);
    put(16'h12AB, 0, 1, 1, 1, 1);
    put(16'h12AB, 1, 1, 1, 1, 1); waitn(4);
    chk("R5 hold while load high", code, 16'h8000);
    // R3: upper lane write
    put(16'h34CD, 1, 0, 0, 1, 1); waitn(2);
    put(16'h34CD, 1, 0, 1, 1, 1);
    put(16'h34CD, 1, 1, 1, 1, 1); waitn(4);
    upd_cnt = 0;
    ld_pulse();
    chk("R2 R3 lanes transferred", code, 16'h34AB);
    chk("R11 one update pulse", 16'(upd_cnt), 16'd1);

    // R4: upper first, then lower
    put(16'h5611, 1, 0, 0, 1, 1);
    put(16'h5611, 1, 0, 1, 1, 1);
    put(16'h2278, 0, 1, 0, 1, 1);
    put(16'h2278, 0, 1, 1, 1, 1);
    put(16'h2278, 1, 1, 1, 1, 1); waitn(4);
    ld_pulse();
    chk("R4 reverse order", code, 16'h5678);

    // R8: write with both lanes deselected
    put(16'hFFFF, 1, 1, 0, 1, 1);
    put(16'hFFFF, 1, 1, 1, 1, 1); waitn(4);
    upd_cnt = 0;
    ld_pulse();
    chk("R8 deselected write ignored", code, 16'h5678);
    chk("R8 no update pulse", 16'(upd_cnt), 16'd0);

    // R12 latency, R6 full pass-through
    put(16'h1111, 0, 0, 0, 0, 1);
    waitn(2);
    chk("R12 not yet visible", code, 16'h5678);
    waitn(1);
    chk("R12 visible on third edge", code, 16'h1111);
    put(16'h2222, 0, 0, 0, 0, 1); waitn(4);
    chk("R6 output follows bus", code, 16'h2222);
    put(16'h2222, 1, 1, 1, 1, 1); waitn(4);

    // R7: lower lane live, upper stored
    put(16'h99EE, 0, 1, 0, 0, 1); waitn(4);
    chk("R7 single lane pass-through", code, 16'h22EE);
    put(16'h99EE, 1, 1, 1, 1, 1); waitn(4);

    // R10: write and load close in the same cycle
    put(16'hAAAA, 0, 0, 0, 1, 1); waitn(4);
    put(16'hAAAA, 0, 0, 0, 0, 1); waitn(4);
    chk("R10 pre-state", code, 16'hAAAA);
    put(16'hBBBB, 0, 0, 1, 1, 1); waitn(4);
    put(16'hBBBB, 1, 1, 1, 1, 1); waitn(4);
    chk("R10 dual edge captures new data", code, 16'hBBBB);

    // R9: clear overrides an active write-through
    mid = 1'b1;
    put(16'h4444, 0, 0, 0, 0, 0); waitn(4);
    chk("R9 clear midscale", code, 16'h8000);
    @(negedge clk) mid = 1'b0;
    waitn(2);
    chk("R9 clear zero", code, 16'h0000);
    put(16'h4444, 1, 1, 1, 1, 0); waitn(2);
    put(16'h4444, 1, 1, 1, 1, 1); waitn(4);
    chk("R9 after clear release", code, 16'h0000);

    // R1: reset with zero strap after a nonzero code
    put(16'h7777, 0, 0, 0, 0, 1); waitn(4);
    chk("R6 pre-reset code", code, 16'h7777);
    put(16'h7777, 1, 1, 1, 1, 1); waitn(4);
    @(negedge clk) rst_n = 1'b0;
    waitn(3);
    chk("R1 reset zero", code, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    waitn(4);
    chk("R1 stays after release", code, 16'h0000);

    finish_run();
  end

endmodule